// File: doc/BRIEF.md
# Buffered Message SPI Master

This block is a single-master SPI engine that runs one whole message from on-chip storage. Software loads the outgoing bytes into a transmit buffer, sets the message length and duplex type in a control word, and issues a single start command that names one of several chip selects. The engine then clocks the full message out MSB first in 8-bit words, in any of the four SPI clock modes. It stores the received bytes in a separate receive buffer and raises a one-cycle done pulse as it releases chip select.

A message can open with a write-only prepend phase of up to 15 bytes, typically a device command or an address. The bytes received during the prepend are dropped, so the receive buffer starts with the first byte clocked after it. Half-duplex read messages drive a programmable fill byte on MOSI. Half-duplex write messages store nothing. Chip select is always released when a message ends; it is never held from one message to the next.

The sequencer has three states. SQ_IDLE leaves chip select released. A start command with a non-zero count moves it to SQ_LOAD, which hands one byte to the shifter and always moves on to SQ_SHIFT. SQ_SHIFT waits for the byte to finish, then returns to SQ_LOAD for the next byte, or to SQ_IDLE after the last one. A soft or hard reset command sends any state straight back to SQ_IDLE.

Top module: `bufspi_master`

## Requirements
- R1: After reset, every cs_n bit is high, done is low, sclk is low, the status register reads 0x0002 (receive buffer empty, not busy), and the control, fill and mode registers read 0.
- R2: Register address 0 is the message control word: count in bits [6:0], message type in bits [15:14], other bits read 0. Address 1 is the command word when written and the status when read: bit 1 means receive buffer empty, bit 2 means command busy, bit 3 means serial busy. Address 2 is the fill byte in bits [7:0]. Address 3 is the mode: bit 0 is CPOL, bit 1 is CPHA.
- R3: A command write with code 3 in bits [3:0] starts a message. cs_n[id] goes low, where id is taken from bits [5:4], and no other cs_n bit goes low. That chip select stays low for all count bytes, and command busy reads 1 while the message runs.
- R4: Every byte is sent MSB first as 8 SCLK cycles, with CPOL and CPHA taken from the mode register. SCLK rests at CPOL between messages.
- R5: done pulses high for exactly one cycle, in the clock cycle right after the last SCLK edge of the final byte. All cs_n bits are high in that same cycle.
- R6: Type 0 (full duplex) sends the transmit buffer bytes and stores every received byte. Type 1 (half-duplex write) sends the transmit buffer bytes and stores nothing. Type 2 (half-duplex read) sends the fill byte for every byte after the prepend and stores the received bytes. Type 3 behaves like type 1.
- R7: Command bits [11:8] give a prepend count P. Bytes 0 to P-1 are taken from the transmit buffer and their received bytes are discarded. The received byte at message index k (k >= P) is stored at receive address k-P. If P >= count, nothing is stored.
- R8: While command busy is set, a further start command is ignored, and so are writes to addresses 0, 2 and 3.
- R9: Command code 1 (soft reset) aborts a running message. Chip select is released, SCLK returns to CPOL and the busy flags clear, no done pulse is given, and the configuration registers keep their values.
- R10: Command code 2 (hard reset) aborts like code 1 and also returns the control, fill and mode registers to 0.
- R11: A start with a count of 0 never asserts chip select, and done pulses in the cycle after the command write.
- R12: The receive-empty flag is set by each accepted start and cleared when the first byte of that message is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| txb_we | input | 1 | Transmit buffer write strobe |
| txb_addr | input | 7 | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write data |
| rxb_addr | input | 6 | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer read data (combinational) |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 4 | Active-low chip selects |
| done | output | 1 | One-cycle message completion pulse |

## Verification
The bench sweeps all four clock modes against all three message types, with a behavioural slave that checks each captured bit and each returned byte. An engine that samples on the wrong edge, or shifts LSB first, would show mismatched bytes in some modes only. A prepend offset error would put received data at the wrong receive address, or store bytes that should have been dropped. If done fires late, or before chip select is released, the cycle-count check between the final SCLK edge and done catches it. Further targeted runs cover the remaining corner cases. A second start or a fill write during a busy message would switch chip selects or change the MOSI fill pattern if it were not ignored. A soft reset that failed to abort would leave chip select low. A zero-length start that asserted chip select would show up as low cycles on the chip-select monitor.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;

    localparam logic [3:0] CMD_NOP  = 4'd0;
    localparam logic [3:0] CMD_SOFT = 4'd1;
    localparam logic [3:0] CMD_HARD = 4'd2;
    localparam logic [3:0] CMD_GO   = 4'd3;

    localparam logic [1:0] MT_DUPLEX = 2'd0;
    localparam logic [1:0] MT_WRITE  = 2'd1;
    localparam logic [1:0] MT_READ   = 2'd2;

    localparam logic [1:0] RA_MSG  = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_FILL = 2'd2;
    localparam logic [1:0] RA_MODE = 2'd3;

    localparam int MAX_PREPEND = 15;
    localparam int PRE_W       = 4;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_SHIFT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/spi_buf.sv
module spi_buf #(
    parameter int DEPTH = 63,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam logic [AW:0] LIM = (AW + 1)'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < LIM)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if ({1'b0, raddr} < LIM) begin
            rdata = mem[raddr];
        end
    end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] tx_byte,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HW-1:0] HLAST = HW'(SCLK_HALF - 1);

    logic [HW-1:0] hcnt;
    logic [3:0]    edge_n;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic [7:0]    rx_next;
    logic          sclk_q;
    logic          edge_now;
    logic          leading;
    logic          do_sample;
    logic          do_shift;

    assign edge_now  = active && (hcnt == HLAST);
    assign leading   = ~edge_n[0];
    assign do_sample = cpha ? ~leading : leading;
    assign do_shift  = cpha ? (leading && (edge_n != 4'd0))
                            : (~leading && (edge_n != 4'd15));
    assign rx_next   = do_sample ? {rx_sr[6:0], miso} : rx_sr;
    assign sclk      = sclk_q;
    assign mosi      = tx_sr[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            hcnt      <= '0;
            edge_n    <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            sclk_q    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                hcnt   <= '0;
                sclk_q <= cpol;
            end else if (start) begin
                active <= 1'b1;
                tx_sr  <= tx_byte;
                hcnt   <= '0;
                edge_n <= '0;
                sclk_q <= cpol;
            end else if (active) begin
                if (edge_now) begin
                    hcnt   <= '0;
                    sclk_q <= ~sclk_q;
                    rx_sr  <= rx_next;
                    edge_n <= edge_n + 4'd1;
                    if (do_shift) begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                    if (edge_n == 4'd15) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                        rx_byte   <= rx_next;
                    end
                end else begin
                    hcnt <= hcnt + HW'(1);
                end
            end else begin
                sclk_q <= cpol;
            end
        end
    end

    AST_SCLK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (sclk == cpol)); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !active); // R5
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
    import spi_msg_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int COUNT_W  = 7,
    parameter int TXA_W    = 7,
    parameter int RXA_W    = 6,
    parameter int RX_DEPTH = 63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [15:0]        cmd_word,
    input  logic [COUNT_W-1:0] msg_count,
    input  logic [1:0]         msg_type,
    input  logic [7:0]         fill_byte,
    input  logic               byte_done,
    input  logic [7:0]         rx_byte,
    input  logic [7:0]         tx_rdata,
    output logic [TXA_W-1:0]   tx_raddr,
    output logic               sh_start,
    output logic [7:0]         sh_byte,
    output logic               sh_abort,
    output logic               rx_we,
    output logic [RXA_W-1:0]   rx_waddr,
    output logic [7:0]         rx_wdata,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               done,
    output logic               cmd_busy,
    output logic               rx_empty
);
    localparam int ID_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam logic [COUNT_W-1:0] RX_LIM = COUNT_W'(RX_DEPTH);

    seq_state_e         state, nxt;
    logic [COUNT_W-1:0] idx_q;
    logic [PRE_W-1:0]   pre_q;
    logic [COUNT_W-1:0] pre_ext;
    logic [COUNT_W-1:0] rx_off;
    logic [3:0]         code;
    logic [ID_W-1:0]    cmd_id;
    logic [NUM_CS-1:0]  cs_sel;
    logic               start_ok;
    logic               past_pre;
    logic               keeps_rx;
    logic               store;
    logic               last;

    assign code     = cmd_word[3:0];
    assign cmd_id   = cmd_word[4 +: ID_W];
    assign cs_sel   = ~(NUM_CS'(1) << cmd_id);
    assign start_ok = cmd_we && (code == CMD_GO) && (state == SQ_IDLE);
    assign sh_abort = cmd_we && ((code == CMD_SOFT) || (code == CMD_HARD));
    assign cmd_busy = (state != SQ_IDLE);

    assign pre_ext  = COUNT_W'(pre_q);
    assign past_pre = (idx_q >= pre_ext);
    assign rx_off   = idx_q - pre_ext;
    assign keeps_rx = (msg_type == MT_DUPLEX) || (msg_type == MT_READ);
    assign store    = past_pre && keeps_rx && (rx_off < RX_LIM);
    assign last     = (idx_q == (msg_count - COUNT_W'(1)));

    assign tx_raddr = idx_q[TXA_W-1:0];
    assign sh_start = (state == SQ_LOAD);
    assign sh_byte  = (past_pre && (msg_type == MT_READ)) ? fill_byte : tx_rdata;
    assign rx_we    = (state == SQ_SHIFT) && byte_done && store;
    assign rx_waddr = rx_off[RXA_W-1:0];
    assign rx_wdata = rx_byte;

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  if (start_ok && (msg_count != '0)) nxt = SQ_LOAD;
            SQ_LOAD:  nxt = SQ_SHIFT;
            SQ_SHIFT: if (byte_done) nxt = last ? SQ_IDLE : SQ_LOAD;
            default:  nxt = SQ_IDLE;
        endcase
        if (sh_abort) nxt = SQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            pre_q    <= '0;
            cs_n     <= '1;
            done     <= 1'b0;
            rx_empty <= 1'b1;
        end else begin
            done <= 1'b0;
            if (sh_abort) begin
                cs_n <= '1;
            end else if (start_ok) begin
                idx_q    <= '0;
                pre_q    <= cmd_word[8 +: PRE_W];
                rx_empty <= 1'b1;
                if (msg_count != '0) cs_n <= cs_sel;
                else                 done <= 1'b1;
            end else if ((state == SQ_SHIFT) && byte_done) begin
                idx_q <= idx_q + COUNT_W'(1);
                if (store) rx_empty <= 1'b0;
                if (last) begin
                    cs_n <= '1;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R3
    AST_IDLE_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> (&cs_n)); // R3
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sh_abort |=> (!done && (&cs_n))); // R9
endmodule

// File: rtl/bufspi_master.sv
module bufspi_master
    import spi_msg_pkg::*;
#(
    parameter int BUF_DEPTH = 63,
    parameter int NUM_CS    = 4,
    parameter int SCLK_HALF = 2,
    localparam int TX_DEPTH = BUF_DEPTH + MAX_PREPEND,
    localparam int COUNT_W  = $clog2(TX_DEPTH + 1),
    localparam int TXA_W    = $clog2(TX_DEPTH),
    localparam int RXA_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              txb_we,
    input  logic [TXA_W-1:0]  txb_addr,
    input  logic [7:0]        txb_wdata,
    input  logic [RXA_W-1:0]  rxb_addr,
    output logic [7:0]        rxb_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              done
);
    logic [COUNT_W-1:0] cnt_q;
    logic [1:0]         type_q;
    logic [7:0]         fill_q;
    logic               cpol_q, cpha_q;
    logic               cmd_we, cfg_ok, hard_rst;
    logic               cmd_busy, rx_empty, ser_busy;
    logic [TXA_W-1:0]   tx_raddr;
    logic [7:0]         tx_rdata;
    logic               sh_start, sh_abort, byte_done;
    logic [7:0]         sh_byte, rx_byte;
    logic               rx_we;
    logic [RXA_W-1:0]   rx_waddr;
    logic [7:0]         rx_wdata;

    assign cmd_we   = reg_we && (reg_addr == RA_CMD);
    assign cfg_ok   = reg_we && !cmd_busy;
    assign hard_rst = cmd_we && (reg_wdata[3:0] == CMD_HARD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            type_q <= '0;
            fill_q <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (hard_rst) begin
            cnt_q  <= '0;
            type_q <= '0;
            fill_q <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (cfg_ok) begin
            unique case (reg_addr)
                RA_MSG: begin
                    cnt_q  <= reg_wdata[COUNT_W-1:0];
                    type_q <= reg_wdata[15:14];
                end
                RA_FILL: fill_q <= reg_wdata[7:0];
                RA_MODE: begin
                    cpol_q <= reg_wdata[0];
                    cpha_q <= reg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_MSG: begin
                reg_rdata[COUNT_W-1:0] = cnt_q;
                reg_rdata[15:14]       = type_q;
            end
            RA_CMD:  reg_rdata[3:1] = {ser_busy, cmd_busy, rx_empty};
            RA_FILL: reg_rdata[7:0] = fill_q;
            default: reg_rdata[1:0] = {cpha_q, cpol_q};
        endcase
    end

    spi_buf #(.DEPTH(TX_DEPTH), .AW(TXA_W)) u_txbuf (
        .clk(clk), .we(txb_we), .waddr(txb_addr), .wdata(txb_wdata),
        .raddr(tx_raddr), .rdata(tx_rdata)
    );

    spi_buf #(.DEPTH(BUF_DEPTH), .AW(RXA_W)) u_rxbuf (
        .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(rxb_addr), .rdata(rxb_rdata)
    );

    spi_msg_seq #(
        .NUM_CS(NUM_CS), .COUNT_W(COUNT_W), .TXA_W(TXA_W),
        .RXA_W(RXA_W), .RX_DEPTH(BUF_DEPTH)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(reg_wdata),
        .msg_count(cnt_q), .msg_type(type_q), .fill_byte(fill_q),
        .byte_done(byte_done), .rx_byte(rx_byte), .tx_rdata(tx_rdata),
        .tx_raddr(tx_raddr), .sh_start(sh_start), .sh_byte(sh_byte),
        .sh_abort(sh_abort), .rx_we(rx_we), .rx_waddr(rx_waddr),
        .rx_wdata(rx_wdata), .cs_n(cs_n), .done(done),
        .cmd_busy(cmd_busy), .rx_empty(rx_empty)
    );

    spi_byte_shifter #(.SCLK_HALF(SCLK_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .abort(sh_abort),
        .tx_byte(sh_byte), .cpol(cpol_q), .cpha(cpha_q), .miso(miso),
        .sclk(sclk), .mosi(mosi), .active(ser_busy),
        .byte_done(byte_done), .rx_byte(rx_byte)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && !$past(hard_rst)) |-> $stable(fill_q)); // R8
endmodule

// File: tb/tb_bufspi_master.sv
module tb_bufspi_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        txb_we = 1'b0;
    logic [6:0]  txb_addr = '0;
    logic [7:0]  txb_wdata = '0;
    logic [5:0]  rxb_addr = '0;
    logic [7:0]  rxb_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;
    logic        done;

    bufspi_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txb_we(txb_we),
        .txb_addr(txb_addr), .txb_wdata(txb_wdata), .rxb_addr(rxb_addr),
        .rxb_rdata(rxb_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model and monitors
    int   s_cpol = 0, s_cpha = 0, s_salt = 0;
    int   s_ob, s_obyte, s_cb, s_cbyte;
    logic [7:0] s_sr;
    logic [7:0] cap [128];
    logic prev_sclk = 1'b0, prev_cs_low = 1'b0;
    logic [3:0] exp_cs = 4'hF;
    int   last_tog = 0, done_cnt = 0, done_late = 0, done_cs_bad = 0;
    int   cs_bad = 0, cs_low_cyc = 0;

    function automatic logic [7:0] txv(int k, int salt);
        return 8'((k * 29 + salt * 13 + 1) & 255);
    endfunction
    function automatic logic [7:0] resp(int k, int salt);
        return 8'((k * 53 + salt * 7 + 3) & 255);
    endfunction

    always @(negedge clk) begin
        logic cs_low, lead;
        logic [7:0] rb;
        cs_low = (cs_n != 4'hF);
        if (done) begin
            done_cnt++;
            if (cs_low_cyc > 0 && (cyc - last_tog) != 1) done_late++;
            if (cs_low) done_cs_bad++;
        end
        if (cs_low) begin
            cs_low_cyc++;
            if (cs_n != exp_cs) cs_bad++;
        end
        if (cs_low && !prev_cs_low) begin
            s_ob = 0; s_obyte = 0; s_cb = 0; s_cbyte = 0;
            if (s_cpha == 0) begin rb = resp(0, s_salt); miso = rb[7]; end
        end else if (cs_low && (sclk != prev_sclk)) begin
            lead = (sclk != 1'(s_cpol));
            if (lead != 1'(s_cpha)) begin
                s_sr = {s_sr[6:0], mosi};
                s_cb++;
                if (s_cb == 8) begin cap[s_cbyte] = s_sr; s_cbyte++; s_cb = 0; end
            end else if (s_cpha == 1) begin
                rb = resp(s_obyte, s_salt); miso = rb[7 - s_ob];
                s_ob++;
                if (s_ob == 8) begin s_ob = 0; s_obyte++; end
            end else begin
                s_ob++;
                if (s_ob == 8) begin s_ob = 0; s_obyte++; end
                rb = resp(s_obyte, s_salt); miso = rb[7 - s_ob];
            end
        end
        if (sclk != prev_sclk) last_tog = cyc;
        prev_sclk = sclk;
        prev_cs_low = cs_low;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_mon();
        done_cnt = 0; done_late = 0; done_cs_bad = 0; cs_bad = 0; cs_low_cyc = 0;
        s_cbyte = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            #1;
            if (done_cnt > 0) begin seen = 1; break; end
        end
    endtask

    task automatic run_msg(input int mode, input int mtype, input int cnt,
                           input int pre, input int id, input int salt, input bit meddle);
        logic [7:0]  fillv, e;
        logic [15:0] rd;
        bit seen;
        int stores;
        s_cpol = mode % 2; s_cpha = mode / 2; s_salt = salt;
        fillv = 8'((salt * 11 + 90) & 255);
        reg_wr(2'd3, 16'(mode));
        reg_wr(2'd2, {8'h00, fillv});
        reg_wr(2'd0, 16'((mtype << 14) | cnt));
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            txb_we = 1'b1; txb_addr = 7'(k); txb_wdata = txv(k, salt);
        end
        @(negedge clk) txb_we = 1'b0;
        exp_cs = ~(4'b0001 << id);
        clear_mon();
        reg_wr(2'd1, 16'((pre << 8) | (id << 4) | 3));
        if (meddle) begin
            repeat (20) @(negedge clk);
            reg_wr(2'd1, 16'((pre << 8) | (((id + 1) % 4) << 4) | 3)); // R8 second start
            reg_wr(2'd2, {8'h00, ~fillv});                            // R8 fill write
            reg_wr(2'd0, 16'h0001);                                   // R8 count write
        end
        wait_done(seen);
        repeat (2) @(negedge clk);
        chk(seen && done_cnt == 1, "R5 done pulse count", done_cnt, 1);
        chk(done_late == 0, "R5 done one cycle after last edge", done_late, 0);
        chk(done_cs_bad == 0, "R5 cs released with done", done_cs_bad, 0);
        chk(cs_bad == 0, "R3 only selected cs low", cs_bad, 0);
        chk(s_cbyte == cnt, "R3 byte count under cs", s_cbyte, cnt);
        for (int k = 0; k < cnt && k < s_cbyte; k++) begin
            e = (k < pre || mtype != 2) ? txv(k, salt) : fillv;
            if (mtype == 2 && k >= pre) chk(cap[k] == e, "R6 fill byte on mosi", cap[k], e);
            else chk(cap[k] == e, "R4 mosi byte", cap[k], e);
        end
        stores = ((mtype == 0 || mtype == 2) && cnt > pre) ? 1 : 0;
        if (stores == 1) begin
            for (int j = 0; j < cnt - pre; j++) begin
                @(negedge clk);
                rxb_addr = 6'(j);
                #1 chk(rxb_rdata == resp(j + pre, salt), "R7 received byte placement",
                       rxb_rdata, resp(j + pre, salt));
            end
        end
        reg_rd(2'd1, rd);
        chk(rd == (stores == 1 ? 16'h0000 : 16'h0002), "R12 status after message",
            rd, (stores == 1 ? 0 : 2));
        if (meddle) begin
            reg_rd(2'd2, rd);
            chk(rd[7:0] == fillv, "R8 fill write ignored while busy", rd, fillv);
            reg_rd(2'd0, rd);
            chk(rd[6:0] == 7'(cnt), "R8 count write ignored while busy", rd[6:0], cnt);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        bit seen;
        int salt;
        s_ob = 0; s_obyte = 0; s_cb = 0; s_cbyte = 0; s_sr = '0;
        repeat (4) @(negedge clk);
        chk(cs_n == 4'hF, "R1 cs_n after reset", cs_n, 15);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        rst_n = 1'b1;
        reg_rd(2'd1, rd); chk(rd == 16'h0002, "R1 status after reset", rd, 2);
        reg_rd(2'd0, rd); chk(rd == 16'h0000, "R1 control after reset", rd, 0);
        reg_rd(2'd2, rd); chk(rd == 16'h0000, "R1 fill after reset", rd, 0);
        reg_rd(2'd3, rd); chk(rd == 16'h0000, "R1 mode after reset", rd, 0);

        // R2 field layout
        reg_wr(2'd0, 16'hFFFF); reg_rd(2'd0, rd);
        chk(rd == 16'hC07F, "R2 control fields", rd, 16'hC07F);
        reg_wr(2'd2, 16'h01A5); reg_rd(2'd2, rd);
        chk(rd == 16'h00A5, "R2 fill field", rd, 16'h00A5);
        reg_wr(2'd3, 16'h000F); reg_rd(2'd3, rd);
        chk(rd == 16'h0003, "R2 mode field", rd, 3);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R4 sclk rests at cpol", sclk, 1);

        // R10 hard reset restores defaults
        reg_wr(2'd1, 16'h0002);
        reg_rd(2'd0, rd); chk(rd == 16'h0000, "R10 control cleared", rd, 0);
        reg_rd(2'd2, rd); chk(rd == 16'h0000, "R10 fill cleared", rd, 0);
        reg_rd(2'd3, rd); chk(rd == 16'h0000, "R10 mode cleared", rd, 0);

        // sweep of modes and types
        salt = 1;
        for (int m = 0; m < 4; m++) begin
            for (int t = 0; t < 3; t++) begin
                run_msg(m, t, 1, 0, m, salt, 0); salt++;
                run_msg(m, t, 9, 3, (m + 1) % 4, salt, 0); salt++;
            end
        end
        run_msg(1, 0, 78, 15, 2, salt, 0); salt++;   // R7 full prepend plus full buffer
        run_msg(2, 2, 63, 0, 3, salt, 0); salt++;
        run_msg(3, 3, 12, 0, 1, salt, 0); salt++;    // R6 type 3 acts as write
        run_msg(0, 0, 4, 6, 0, salt, 0); salt++;     // R7 prepend covers message
        run_msg(0, 2, 5, 0, 1, salt, 1); salt++;     // R8 writes while busy

        // R11 zero-length start
        reg_wr(2'd0, 16'h0000);
        clear_mon();
        reg_wr(2'd1, 16'h0013);
        @(negedge clk);
        chk(done_cnt == 1, "R11 done for empty message", done_cnt, 1);
        chk(cs_low_cyc == 0, "R11 no chip select", cs_low_cyc, 0);

        // R9 soft reset mid-message
        s_cpol = 1; s_cpha = 0; s_salt = 99;
        reg_wr(2'd3, 16'h0001);
        reg_wr(2'd0, 16'd20);
        exp_cs = 4'b1011;
        clear_mon();
        reg_wr(2'd1, 16'h0023);
        repeat (60) @(negedge clk);
        reg_rd(2'd1, rd);
        chk(rd[2] == 1'b1, "R3 command busy during message", rd[2], 1);
        reg_wr(2'd1, 16'h0001);
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF, "R9 cs released on abort", cs_n, 15);
        chk(sclk == 1'b1, "R9 sclk back at cpol", sclk, 1);
        reg_rd(2'd1, rd);
        chk(rd[3:2] == 2'b00, "R9 busy cleared", rd[3:2], 0);
        chk(done_cnt == 0, "R9 no done on abort", done_cnt, 0);
        reg_rd(2'd3, rd);
        chk(rd == 16'h0001, "R9 mode kept", rd, 1);
        reg_rd(2'd0, rd);
        chk(rd == 16'd20, "R9 control kept", rd, 20);
        run_msg(0, 0, 3, 0, 2, salt, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule